// File: doc/BRIEF.md
# UART Transmit Framer

This block serialises bytes onto an asynchronous serial line. It takes bytes from an external show-ahead transmit FIFO and wraps each one in a frame. A frame is a low start bit, then 5 to 8 data bits sent least significant bit first. An optional parity bit follows, then one or two high stop bits. Word length, parity mode and stop count are configuration inputs that can change at run time. The block captures them when a frame begins, so each frame is sent with one consistent format.

Timing comes from a clock-enable input, `baud_tick`, that pulses at eight times the baud rate. Every bit on the line lasts exactly eight of these pulses. When flow control is enabled, a deasserted clear-to-send input holds off new frames. A frame that has already started always runs to its end. The `busy` output is high for the whole frame, so the transmitter is fully drained when `busy` is low and the FIFO is empty.

Top module: `uart_tx_framer`

## Requirements
- R1: After a synchronous reset, `txd` is 1 (idle line level), `busy` is 0 and `fifo_pop` is 0.
- R2: A frame starts when the framer is idle and `fifo_empty` is 0, provided flow control permits. On that clock edge the byte on `fifo_data` is captured, `txd` goes low and `busy` goes high. `fifo_pop` is high for exactly one cycle, in the cycle that follows, and only once per frame.
- R3: `cfg_len` selects the data bit count: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits go out least significant bit first, right after the start bit. Byte bits above the selected length are never sent.
- R4: Every bit of a frame lasts exactly 8 `baud_tick` pulses. The start bit counts from the edge that starts the frame, and `txd` only changes at bit boundaries.
- R5: `cfg_two_stop` = 1 sends two stop bits (high); 0 sends one.
- R6: `cfg_parity` selects the parity bit that follows the data. Code 4 is odd parity: the data bits plus the parity bit hold an odd number of ones. Code 6 is even parity, code 5 is a parity bit that is always 1, and code 7 is a parity bit that is always 0. Code 0 sends no parity bit.
- R7: Parity codes 1, 2 and 3 behave exactly like code 0: no parity bit is sent.
- R8: While `cfg_flow_en` is 1 and `cts` is 0, no new frame starts and nothing is popped. A frame already in progress completes unchanged if `cts` falls during it.
- R9: `busy` is high from the first cycle of the start bit until the end of the last stop bit, and then returns to 0. A frame of N bits holds `busy` for exactly 8·N ticks.
- R10: The configuration inputs are sampled only when a frame starts. Changing them during a frame affects only the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Clock enable at 8x the baud rate |
| fifo_data | input | 8 | Byte at the head of the transmit FIFO (show-ahead) |
| fifo_empty | input | 1 | FIFO holds no byte |
| cfg_len | input | 2 | Word length code (0..3 gives 5..8 bits) |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one stop bit |
| cfg_parity | input | 3 | Parity mode code (0 none, 4 odd, 5 mark, 6 even, 7 space) |
| cfg_flow_en | input | 1 | Enable clear-to-send gating of new frames |
| cts | input | 1 | Clear to send, active high |
| txd | output | 1 | Serial output, idle high |
| fifo_pop | output | 1 | One-cycle pop strobe to the FIFO |
| busy | output | 1 | A frame is on the line |

## Verification
Errors in the state machine or the bit counter show up at `txd` within one bit time (8 ticks). A wrong length, parity choice or stop count makes the bit after the data differ from the expected frame, or changes the number of ticks `busy` stays high. A stale or mis-sampled configuration shows up only on the frame after a mid-frame change, so the bench sends two frames around such a change. A pop that repeats or goes missing shows up as a skipped or resent byte on the next frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_t;

  localparam logic [2:0] PAR_ODD   = 3'd4;
  localparam logic [2:0] PAR_MARK  = 3'd5;
  localparam logic [2:0] PAR_EVEN  = 3'd6;
  localparam logic [2:0] PAR_SPACE = 3'd7;

  typedef struct packed {
    logic [3:0] nbits;
    logic       par_en;
    logic       par_val;
    logic       two_stop;
  } frame_cfg_t;

endpackage

// File: rtl/tx_cfg_decode.sv
module tx_cfg_decode
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        len_code,
  input  logic [2:0]        par_code,
  input  logic              two_stop,
  input  logic [DATA_W-1:0] data,
  output frame_cfg_t        cfg
);

  logic [3:0]        nbits_w;
  logic [DATA_W-1:0] keep_mask;
  logic              ones_odd;

  assign nbits_w = 4'd5 + {2'b00, len_code};

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign keep_mask[i] = (4'(i) < nbits_w);
  end

  assign ones_odd = ^(data & keep_mask);

  always_comb begin
    cfg.nbits    = nbits_w;
    cfg.two_stop = two_stop;
    cfg.par_en   = 1'b1;
    cfg.par_val  = 1'b0;
    case (par_code)
      PAR_ODD:   cfg.par_val = ~ones_odd;
      PAR_EVEN:  cfg.par_val = ones_odd;
      PAR_MARK:  cfg.par_val = 1'b1;
      PAR_SPACE: cfg.par_val = 1'b0;
      default:   cfg.par_en  = 1'b0;
    endcase
  end

endmodule

// File: rtl/tx_tick_div.sv
module tx_tick_div #(
  parameter int TICKS_PER_BIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic bit_end
);

  localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

  logic [CW-1:0] cnt;

  assign bit_end = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= bit_end ? '0 : cnt + 1'b1;
    end
  end

  // R4: the phase counter only moves on a tick
  p_phase_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!clear && !tick) |=> $stable(cnt));

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_empty,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_two_stop,
  input  logic [2:0]        cfg_parity,
  input  logic              cfg_flow_en,
  input  logic              cts,
  output logic              txd,
  output logic              fifo_pop,
  output logic              busy
);

  tx_state_t         state;
  frame_cfg_t        cfg_d;
  frame_cfg_t        cfg_q;
  logic [DATA_W-1:0] shreg;
  logic [3:0]        bit_cnt;
  logic              stop_second;
  logic              start_ok;
  logic              bit_end;

  assign start_ok = (state == ST_IDLE) && !fifo_empty && (!cfg_flow_en || cts);

  tx_cfg_decode #(.DATA_W(DATA_W)) u_decode (
    .len_code (cfg_len),
    .par_code (cfg_parity),
    .two_stop (cfg_two_stop),
    .data     (fifo_data),
    .cfg      (cfg_d)
  );

  tx_tick_div #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_ticks (
    .clk     (clk),
    .rst     (rst),
    .clear   (start_ok),
    .tick    (baud_tick),
    .bit_end (bit_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cfg_q       <= '0;
      shreg       <= '0;
      bit_cnt     <= '0;
      stop_second <= 1'b0;
      txd         <= 1'b1;
      busy        <= 1'b0;
      fifo_pop    <= 1'b0;
    end else begin
      fifo_pop <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_ok) begin
            shreg    <= fifo_data;
            cfg_q    <= cfg_d;
            txd      <= 1'b0;
            busy     <= 1'b1;
            fifo_pop <= 1'b1;
            state    <= ST_START;
          end
        end
        ST_START: begin
          if (bit_end) begin
            txd         <= shreg[0];
            shreg       <= shreg >> 1;
            bit_cnt     <= 4'd1;
            stop_second <= 1'b0;
            state       <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            if (bit_cnt == cfg_q.nbits) begin
              if (cfg_q.par_en) begin
                txd   <= cfg_q.par_val;
                state <= ST_PAR;
              end else begin
                txd   <= 1'b1;
                state <= ST_STOP;
              end
            end else begin
              txd     <= shreg[0];
              shreg   <= shreg >> 1;
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_PAR: begin
          if (bit_end) begin
            txd   <= 1'b1;
            state <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (bit_end) begin
            if (cfg_q.two_stop && !stop_second) begin
              stop_second <= 1'b1;
            end else begin
              busy  <= 1'b0;
              state <= ST_IDLE;
            end
          end
        end
        default: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
          txd   <= 1'b1;
        end
      endcase
    end
  end

  // R1: line sits high whenever no frame is running
  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);

  // R2: pop is a single-cycle strobe
  p_pop_single_r2: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !fifo_pop);

  // R2: pop accompanies a fresh start bit
  p_pop_start_r2: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> (busy && !txd));

  // R2: pop only follows a non-empty FIFO
  p_pop_data_r2: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> $past(!fifo_empty));

  // R4: line level changes only at bit boundaries
  p_bit_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !bit_end) |=> $stable(txd));

  // R8: flow control blocks a new frame
  p_flow_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && cfg_flow_en && !cts) |=> !busy);

  // R10: captured frame format stays fixed during a frame
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cfg_q));

endmodule

// File: tb/uart_tx_framer_tb_top.sv
`timescale 1ns/1ps
module uart_tx_framer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [7:0] fifo_data;
  logic       fifo_empty;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_two_stop = 1'b0;
  logic [2:0] cfg_parity = 3'd0;
  logic       cfg_flow_en = 1'b0;
  logic       cts = 1'b1;
  logic       txd, fifo_pop, busy;

  logic [7:0] fmem [0:15];
  logic [3:0] wr_ptr = 4'd0;
  logic [3:0] rd_ptr = 4'd0;
  int         tick_phase = 0;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  assign fifo_empty = (wr_ptr == rd_ptr);
  assign fifo_data  = fmem[rd_ptr];

  always @(posedge clk) begin
    if (fifo_pop) rd_ptr <= rd_ptr + 4'd1;
  end

  initial begin
    forever begin
      @(posedge clk);
      #1;
      tick <= (tick_phase == 3);
      tick_phase = (tick_phase + 1) % 4;
    end
  end

  uart_tx_framer dut_i (
    .clk(clk), .rst(rst), .baud_tick(tick),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .cfg_len(cfg_len), .cfg_two_stop(cfg_two_stop), .cfg_parity(cfg_parity),
    .cfg_flow_en(cfg_flow_en), .cts(cts),
    .txd(txd), .fifo_pop(fifo_pop), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    fmem[wr_ptr] = b;
    wr_ptr = wr_ptr + 4'd1;
  endtask

  function automatic int frame_len(input int nb, input logic [2:0] pc, input bit s2);
    return 1 + nb + ((pc >= 3'd4) ? 1 : 0) + (s2 ? 2 : 1);
  endfunction

  function automatic logic [15:0] exp_frame(input logic [7:0] d, input int nb,
                                            input logic [2:0] pc, input bit s2);
    logic [15:0] f;
    int idx;
    int ones;
    f = '1;
    f[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < nb; i++) begin
      f[1+i] = d[i];
      if (d[i]) ones++;
    end
    idx = 1 + nb;
    if (pc == 3'd4) begin f[idx] = (ones % 2 == 0); idx++; end
    if (pc == 3'd6) begin f[idx] = (ones % 2 == 1); idx++; end
    if (pc == 3'd5) begin f[idx] = 1'b1; idx++; end
    if (pc == 3'd7) begin f[idx] = 1'b0; idx++; end
    for (int i = idx; i < 16; i++) f[i] = 1'b1;
    return f;
  endfunction

  // samples the centre of each of n bits of the next frame
  task automatic recv(input int n, output logic [15:0] bits, output int pop_seen);
    int k;
    int idx;
    bits = '1;
    @(negedge clk);
    while (txd) @(negedge clk);
    pop_seen = fifo_pop;
    k = 0;
    idx = 0;
    forever begin
      if (tick) begin
        k++;
        if (k % 8 == 4) begin
          bits[idx] = txd;
          idx++;
        end
      end
      if (idx == n) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic measure_busy(output int t);
    @(negedge clk);
    while (!busy) @(negedge clk);
    t = 0;
    while (busy) begin
      if (tick) t++;
      @(negedge clk);
    end
  endtask

  task automatic measure_low(output int t);
    @(negedge clk);
    while (txd) @(negedge clk);
    t = 0;
    while (!txd) begin
      if (tick) t++;
      @(negedge clk);
    end
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic [2:0] p, input bit s2);
    cfg_len = l;
    cfg_parity = p;
    cfg_two_stop = s2;
  endtask

  task automatic send_check(input string req, input logic [7:0] d, input logic [1:0] l,
                            input logic [2:0] p, input bit s2);
    logic [15:0] got;
    logic [15:0] exp;
    int n;
    int pop_seen;
    set_cfg(l, p, s2);
    n = frame_len(5 + int'(l), p, s2);
    exp = exp_frame(d, 5 + int'(l), p, s2);
    push(d);
    recv(n, got, pop_seen);
    wait_idle();
    chk(req, int'(got & ((16'd1 << n) - 16'd1)), int'(exp & ((16'd1 << n) - 16'd1)));
    chk("R1 line high after frame", int'(txd), 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 txd in reset", int'(txd), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 txd after reset", int'(txd), 1);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 pop after reset", int'(fifo_pop), 0);
  endtask

  task automatic t_basic();
    logic [15:0] got;
    int pop_seen;
    set_cfg(2'd3, 3'd0, 1'b0);
    push(8'hA5);
    push(8'h3C);
    recv(10, got, pop_seen);
    chk("R2 pop with first start bit", pop_seen, 1);
    chk("R3 first byte 8N1", int'(got[9:0]), int'(exp_frame(8'hA5, 8, 3'd0, 1'b0) & 16'h3FF));
    recv(10, got, pop_seen);
    chk("R2 pop with second start bit", pop_seen, 1);
    chk("R3 second byte 8N1", int'(got[9:0]), int'(exp_frame(8'h3C, 8, 3'd0, 1'b0) & 16'h3FF));
    wait_idle();
    chk("R2 one pop per frame", int'(rd_ptr), int'(wr_ptr));
    chk("R9 busy low after frames", int'(busy), 0);
  endtask

  task automatic t_lengths();
    for (int l = 0; l < 4; l++) begin
      send_check("R3 word length", 8'hB6, 2'(l), 3'd0, 1'b0);
    end
    send_check("R3 upper bits dropped", 8'hE0, 2'd0, 3'd0, 1'b0);
  endtask

  task automatic t_parity();
    send_check("R6 odd parity even count", 8'h03, 2'd3, 3'd4, 1'b0);
    send_check("R6 odd parity odd count", 8'h07, 2'd3, 3'd4, 1'b0);
    send_check("R6 even parity odd count", 8'h07, 2'd3, 3'd6, 1'b0);
    send_check("R6 even parity 5 bits", 8'hE1, 2'd0, 3'd6, 1'b0);
    send_check("R6 mark parity", 8'h00, 2'd3, 3'd5, 1'b0);
    send_check("R6 space parity", 8'hFF, 2'd3, 3'd7, 1'b0);
    send_check("R6 no parity code 0", 8'h00, 2'd3, 3'd0, 1'b0);
    for (int c = 1; c < 4; c++) begin
      send_check("R7 reserved code acts as none", 8'h00, 2'd3, 3'(c), 1'b0);
    end
  endtask

  task automatic t_stop_time();
    int t;
    set_cfg(2'd3, 3'd0, 1'b0);
    push(8'h55);
    measure_busy(t);
    chk("R9 busy ticks 8N1", t, 80);
    set_cfg(2'd3, 3'd0, 1'b1);
    push(8'h55);
    measure_busy(t);
    chk("R5 busy ticks 8N2", t, 88);
    set_cfg(2'd0, 3'd6, 1'b1);
    push(8'h55);
    measure_busy(t);
    chk("R5 busy ticks 5E2", t, 72);
    send_check("R5 two stop bits high", 8'h0F, 2'd1, 3'd7, 1'b1);
  endtask

  task automatic t_bit_time();
    int t;
    set_cfg(2'd3, 3'd0, 1'b0);
    push(8'h00);
    measure_low(t);
    chk("R4 low run start plus 8 zeros", t, 72);
    wait_idle();
    set_cfg(2'd0, 3'd7, 1'b0);
    push(8'h00);
    measure_low(t);
    chk("R4 low run start, 5 zeros, space", t, 56);
    wait_idle();
  endtask

  task automatic t_flow();
    logic [15:0] got;
    int pop_seen;
    set_cfg(2'd3, 3'd0, 1'b0);
    cfg_flow_en = 1'b1;
    cts = 1'b0;
    push(8'h96);
    repeat (300) @(negedge clk);
    chk("R8 held: busy", int'(busy), 0);
    chk("R8 held: line", int'(txd), 1);
    chk("R8 held: no pop", int'(fifo_empty), 0);
    cts = 1'b1;
    fork
      recv(10, got, pop_seen);
      begin
        repeat (60) @(negedge clk);
        cts = 1'b0;
      end
    join
    wait_idle();
    chk("R8 frame completes after cts drop", int'(got[9:0]),
        int'(exp_frame(8'h96, 8, 3'd0, 1'b0) & 16'h3FF));
    cts = 1'b1;
    cfg_flow_en = 1'b0;
  endtask

  task automatic t_cfg_mid();
    logic [15:0] got;
    int pop_seen;
    set_cfg(2'd3, 3'd0, 1'b0);
    push(8'h5A);
    fork
      recv(10, got, pop_seen);
      begin
        repeat (20) @(negedge clk);
        set_cfg(2'd0, 3'd6, 1'b1);
      end
    join
    wait_idle();
    chk("R10 running frame keeps format", int'(got[9:0]),
        int'(exp_frame(8'h5A, 8, 3'd0, 1'b0) & 16'h3FF));
    push(8'h5A);
    recv(9, got, pop_seen);
    wait_idle();
    chk("R10 next frame uses new format", int'(got[8:0]),
        int'(exp_frame(8'h5A, 5, 3'd6, 1'b1) & 16'h1FF));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_lengths();
    t_parity();
    t_stop_time();
    t_bit_time();
    t_flow();
    t_cfg_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule